// File: doc/BRIEF.md
# Rectangle Blit Engine with Binary Raster Operations

The block copies a rectangle of 8-bit pixels from a source map to a destination map held in one shared memory. Software loads start addresses, map pitches, the rectangle size, walk directions, two mix codes and two fixed colours through a small register write port. Writing a valid operation code while the engine is idle launches the copy. The engine then walks the rectangle one pixel at a time, and for each pixel it does three things: it reads the source, reads the destination, and writes back a combination of the two chosen by a 4-bit mix code. The busy output stays high until the last pixel has been written.

Pitches and sizes are stored as the real value minus one. Each axis has its own direction bit, so a copy can run backwards on either axis. A move between overlapping regions therefore comes out right when the walk starts from the far end. The foreground operand is either the source pixel itself or a fixed colour. In fixed-colour mode each source pixel acts as a mask: a non-zero pixel selects the foreground colour and mix, and a zero pixel selects the background colour and mix.

Top module: `blit_engine`

## Requirements
- R1: After reset, busy_o is low. While busy_o is low, mem_req_o and mem_we_o are low.
- R2: A write to the operation register (address 10) with bits [4:0] equal to 0x08 or 0x09 while idle starts a blit. busy_o is high in the cycle after that write and stays high until the last pixel has been written.
- R3: A write to the operation register while idle with bits [4:0] holding any other value starts nothing. busy_o stays low and memory is not written.
- R4: While busy_o is high, every configuration write is ignored, including a write to the operation register. The running blit completes with the settings it started with.
- R5: The width and height registers (12 bits each) hold size minus one, so a blit writes exactly (width+1)*(height+1) pixels.
- R6: Pixel addresses are start ± row*(pitch+1) ± column, modulo 2^22. Bit 0 of the direction register set makes the column step negative (right to left). Bit 1 set makes the row step negative (bottom up).
- R7: Pixels are visited row by row and, within a row, column by column, each in its chosen direction. Each write is complete before the next pixel is read, so overlapping copies walked from the far end are correct.
- R8: Mix codes produce: 0 zero, 1 S&D, 2 S&~D, 3 S, 4 ~S&D, 5 D, 6 S^D, 7 S|D, 8 ~S&~D, 9 S^~D, A ~D, B S|~D, C ~S, D ~S|D, E ~S|~D, F all ones.
- R9: With operation bit 5 set, the foreground operand S is the source pixel and the foreground mix (mix register bits [3:0]) is always used.
- R10: With operation bit 5 clear, a non-zero source pixel gives S = foreground colour (address 8) with the foreground mix. A zero source pixel gives S = background colour (address 9) with the background mix (mix register bits [7:4]).
- R11: Operation code 0x09 complements the source pixel before it is used as an operand or as a mask. Code 0x08 uses it unchanged.
- R12: Each pixel takes three cycles (source read, destination read, write), with read data returned one cycle after the request. busy_o is high for exactly 3*(pixel count) cycles.
- R13: Register addresses: 0 source start, 1 destination start, 2 source pitch, 3 destination pitch, 4 width-1, 5 height-1, 6 direction, 7 mix codes, 8 foreground colour, 9 background colour, 10 operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 4 | Configuration register address |
| cfg_wdata_i | input | 22 | Configuration write data |
| busy_o | output | 1 | Engine working |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 22 | Memory pixel address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, valid one cycle after a read request |

## Verification
The bench builds the engine with its default parameters: 22-bit addresses, 12-bit pitch and size fields and 8-bit pixels. Its memory model decodes the low 12 address bits, which keeps small rectangles with any pitch and either walk direction within reach. This covers overlapping moves in both axes, all sixteen mix codes, both foreground sources and the inverted operation. Per-pixel timing is checked through the exact busy duration and write count of each rectangle.

// File: rtl/blit_pkg.sv
package blit_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RD_SRC = 2'd1,
    ST_RD_DST = 2'd2,
    ST_WR     = 2'd3
  } blit_state_e;

  localparam int unsigned CFG_AW = 4;

  localparam logic [CFG_AW-1:0] REG_SRC_START = 4'd0;
  localparam logic [CFG_AW-1:0] REG_DST_START = 4'd1;
  localparam logic [CFG_AW-1:0] REG_SRC_PITCH = 4'd2;
  localparam logic [CFG_AW-1:0] REG_DST_PITCH = 4'd3;
  localparam logic [CFG_AW-1:0] REG_WIDTH     = 4'd4;
  localparam logic [CFG_AW-1:0] REG_HEIGHT    = 4'd5;
  localparam logic [CFG_AW-1:0] REG_DIR       = 4'd6;
  localparam logic [CFG_AW-1:0] REG_MIX       = 4'd7;
  localparam logic [CFG_AW-1:0] REG_FG_COL    = 4'd8;
  localparam logic [CFG_AW-1:0] REG_BG_COL    = 4'd9;
  localparam logic [CFG_AW-1:0] REG_OP        = 4'd10;

  localparam logic [4:0] OPC_BLIT     = 5'h08;
  localparam logic [4:0] OPC_BLIT_INV = 5'h09;
  localparam int unsigned OP_FG_SRC_BIT = 5;
endpackage

// File: rtl/blit_rop.sv
module blit_rop #(
  parameter int unsigned DW = 8
) (
  input  logic [3:0]    code_i,
  input  logic [DW-1:0] s_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] r_o
);
  always_comb begin
    unique case (code_i)
      4'h0: r_o = '0;
      4'h1: r_o = s_i & d_i;
      4'h2: r_o = s_i & ~d_i;
      4'h3: r_o = s_i;
      4'h4: r_o = ~s_i & d_i;
      4'h5: r_o = d_i;
      4'h6: r_o = s_i ^ d_i;
      4'h7: r_o = s_i | d_i;
      4'h8: r_o = ~s_i & ~d_i;
      4'h9: r_o = s_i ^ ~d_i;
      4'ha: r_o = ~d_i;
      4'hb: r_o = s_i | ~d_i;
      4'hc: r_o = ~s_i;
      4'hd: r_o = ~s_i | d_i;
      4'he: r_o = ~s_i | ~d_i;
      default: r_o = '1;
    endcase
  end
endmodule

// File: rtl/blit_regs.sv
module blit_regs
  import blit_pkg::*;
#(
  parameter int unsigned AW = 22,
  parameter int unsigned PW = 12,
  parameter int unsigned DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [AW-1:0]     cfg_wdata_i,
  input  logic              busy_i,
  output logic [AW-1:0]     src_start_o,
  output logic [AW-1:0]     dst_start_o,
  output logic [PW-1:0]     src_pitch_o,
  output logic [PW-1:0]     dst_pitch_o,
  output logic [PW-1:0]     width_m1_o,
  output logic [PW-1:0]     height_m1_o,
  output logic              x_neg_o,
  output logic              y_neg_o,
  output logic [3:0]        fg_mix_o,
  output logic [3:0]        bg_mix_o,
  output logic [DW-1:0]     fg_col_o,
  output logic [DW-1:0]     bg_col_o,
  output logic              inv_o,
  output logic              fg_src_o,
  output logic              start_o
);
  logic wr_ok;
  logic op_valid;

  assign wr_ok    = cfg_we_i && !busy_i;
  assign op_valid = (cfg_wdata_i[4:0] == OPC_BLIT) || (cfg_wdata_i[4:0] == OPC_BLIT_INV);
  assign start_o  = wr_ok && (cfg_addr_i == REG_OP) && op_valid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_start_o <= '0;
      dst_start_o <= '0;
      src_pitch_o <= '0;
      dst_pitch_o <= '0;
      width_m1_o  <= '0;
      height_m1_o <= '0;
      x_neg_o     <= 1'b0;
      y_neg_o     <= 1'b0;
      fg_mix_o    <= '0;
      bg_mix_o    <= '0;
      fg_col_o    <= '0;
      bg_col_o    <= '0;
      inv_o       <= 1'b0;
      fg_src_o    <= 1'b0;
    end else if (wr_ok) begin
      unique case (cfg_addr_i)
        REG_SRC_START: src_start_o <= cfg_wdata_i;
        REG_DST_START: dst_start_o <= cfg_wdata_i;
        REG_SRC_PITCH: src_pitch_o <= cfg_wdata_i[PW-1:0];
        REG_DST_PITCH: dst_pitch_o <= cfg_wdata_i[PW-1:0];
        REG_WIDTH:     width_m1_o  <= cfg_wdata_i[PW-1:0];
        REG_HEIGHT:    height_m1_o <= cfg_wdata_i[PW-1:0];
        REG_DIR: begin
          x_neg_o <= cfg_wdata_i[0];
          y_neg_o <= cfg_wdata_i[1];
        end
        REG_MIX: begin
          fg_mix_o <= cfg_wdata_i[3:0];
          bg_mix_o <= cfg_wdata_i[7:4];
        end
        REG_FG_COL: fg_col_o <= cfg_wdata_i[DW-1:0];
        REG_BG_COL: bg_col_o <= cfg_wdata_i[DW-1:0];
        REG_OP: begin
          if (op_valid) begin
            inv_o    <= (cfg_wdata_i[4:0] == OPC_BLIT_INV);
            fg_src_o <= cfg_wdata_i[OP_FG_SRC_BIT];
          end
        end
        default: ;
      endcase
    end
  end

  // R4: configuration frozen while a blit runs
  a_r4_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> ($stable(src_start_o) && $stable(dst_start_o) && $stable(width_m1_o) &&
                $stable(height_m1_o) && $stable(fg_mix_o) && $stable(inv_o)));
endmodule

// File: rtl/blit_walker.sv
module blit_walker #(
  parameter int unsigned AW = 22,
  parameter int unsigned PW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [AW-1:0] src_start_i,
  input  logic [AW-1:0] dst_start_i,
  input  logic [PW-1:0] src_pitch_i,
  input  logic [PW-1:0] dst_pitch_i,
  input  logic [PW-1:0] width_m1_i,
  input  logic [PW-1:0] height_m1_i,
  input  logic          x_neg_i,
  input  logic          y_neg_i,
  output logic [AW-1:0] src_addr_o,
  output logic [AW-1:0] dst_addr_o,
  output logic          last_o
);
  logic [PW-1:0] col_q, row_q;
  logic [AW-1:0] src_row_q, dst_row_q;
  logic [AW-1:0] src_step, dst_step, col_off;
  logic          row_end;

  assign src_step = AW'(src_pitch_i) + AW'(1);
  assign dst_step = AW'(dst_pitch_i) + AW'(1);
  assign col_off  = AW'(col_q);
  assign row_end  = (col_q == width_m1_i);
  assign last_o   = row_end && (row_q == height_m1_i);

  assign src_addr_o = x_neg_i ? (src_row_q - col_off) : (src_row_q + col_off);
  assign dst_addr_o = x_neg_i ? (dst_row_q - col_off) : (dst_row_q + col_off);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q     <= '0;
      row_q     <= '0;
      src_row_q <= '0;
      dst_row_q <= '0;
    end else if (load_i) begin
      col_q     <= '0;
      row_q     <= '0;
      src_row_q <= src_start_i;
      dst_row_q <= dst_start_i;
    end else if (step_i) begin
      if (row_end) begin
        col_q     <= '0;
        row_q     <= row_q + 1'b1;
        src_row_q <= y_neg_i ? (src_row_q - src_step) : (src_row_q + src_step);
        dst_row_q <= y_neg_i ? (dst_row_q - dst_step) : (dst_row_q + dst_step);
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end

  // R5: counters never pass the loaded size
  a_r5_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> (col_q <= width_m1_i) && (row_q <= height_m1_i));
endmodule

// File: rtl/blit_ctrl.sv
module blit_ctrl
  import blit_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic last_i,
  output logic busy_o,
  output logic load_o,
  output logic step_o,
  output logic rd_src_o,
  output logic rd_dst_o,
  output logic wr_o
);
  blit_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_RD_SRC;
      ST_RD_SRC: state_d = ST_RD_DST;
      ST_RD_DST: state_d = ST_WR;
      ST_WR:     state_d = last_i ? ST_IDLE : ST_RD_SRC;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign load_o   = (state_q == ST_IDLE) && start_i;
  assign rd_src_o = (state_q == ST_RD_SRC);
  assign rd_dst_o = (state_q == ST_RD_DST);
  assign wr_o     = (state_q == ST_WR);
  assign step_o   = wr_o;

  // R12: three-phase pixel sequence
  a_r12_src_then_dst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_src_o |=> rd_dst_o);
  a_r12_dst_then_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_dst_o |=> wr_o);
  a_r12_no_back_to_back_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |=> !wr_o);
endmodule

// File: rtl/blit_engine.sv
module blit_engine
  import blit_pkg::*;
#(
  parameter int unsigned AW = 22,
  parameter int unsigned PW = 12,
  parameter int unsigned DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [AW-1:0]     cfg_wdata_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic [DW-1:0]     mem_rdata_i
);
  logic [AW-1:0] src_start, dst_start, src_addr, dst_addr;
  logic [PW-1:0] src_pitch, dst_pitch, width_m1, height_m1;
  logic          x_neg, y_neg, inv, fg_src, start, last;
  logic [3:0]    fg_mix, bg_mix, mix_code;
  logic [DW-1:0] fg_col, bg_col, src_q, src_eff, s_opnd;
  logic          load, step, rd_src, rd_dst, wr, is_fg;

  blit_regs #(.AW(AW), .PW(PW), .DW(DW)) u_regs (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .busy_i(busy_o),
    .src_start_o(src_start), .dst_start_o(dst_start),
    .src_pitch_o(src_pitch), .dst_pitch_o(dst_pitch),
    .width_m1_o(width_m1), .height_m1_o(height_m1),
    .x_neg_o(x_neg), .y_neg_o(y_neg),
    .fg_mix_o(fg_mix), .bg_mix_o(bg_mix),
    .fg_col_o(fg_col), .bg_col_o(bg_col),
    .inv_o(inv), .fg_src_o(fg_src), .start_o(start)
  );

  blit_ctrl u_ctrl (
    .clk_i, .rst_ni, .start_i(start), .last_i(last),
    .busy_o, .load_o(load), .step_o(step),
    .rd_src_o(rd_src), .rd_dst_o(rd_dst), .wr_o(wr)
  );

  blit_walker #(.AW(AW), .PW(PW)) u_walk (
    .clk_i, .rst_ni, .active_i(busy_o), .load_i(load), .step_i(step),
    .src_start_i(src_start), .dst_start_i(dst_start),
    .src_pitch_i(src_pitch), .dst_pitch_i(dst_pitch),
    .width_m1_i(width_m1), .height_m1_i(height_m1),
    .x_neg_i(x_neg), .y_neg_i(y_neg),
    .src_addr_o(src_addr), .dst_addr_o(dst_addr), .last_o(last)
  );

  // source pixel returns during the destination-read cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     src_q <= '0;
    else if (rd_dst) src_q <= mem_rdata_i;
  end

  assign src_eff  = inv ? ~src_q : src_q;
  assign is_fg    = fg_src || (src_eff != '0);
  assign mix_code = is_fg ? fg_mix : bg_mix;
  assign s_opnd   = fg_src ? src_eff : (is_fg ? fg_col : bg_col);

  blit_rop #(.DW(DW)) u_rop (
    .code_i(mix_code), .s_i(s_opnd), .d_i(mem_rdata_i), .r_o(mem_wdata_o)
  );

  assign mem_req_o  = rd_src || rd_dst || wr;
  assign mem_we_o   = wr;
  assign mem_addr_o = rd_src ? src_addr : dst_addr;

  // R1: no memory traffic while idle
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !mem_we_o);
  // R2: accepted start raises busy next cycle
  a_r2_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !busy_o && cfg_addr_i == REG_OP &&
     (cfg_wdata_i[4:0] == OPC_BLIT || cfg_wdata_i[4:0] == OPC_BLIT_INV)) |=> busy_o);
  // R7: busy only drops right after a write
  a_r7_end_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(mem_we_o));
endmodule

// File: tb/sim_blit_engine.sv
module sim_blit_engine;
  import blit_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [21:0] cfg_wdata = '0;
  logic        busy, mem_req, mem_we;
  logic [21:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  logic [7:0] mem [4096];
  logic [7:0] expm [4096];
  int n_chk = 0, n_bad = 0, wr_cnt = 0;

  int c_src, c_dst, c_sp, c_dp, c_w, c_h, c_dir, c_mix, c_fg, c_bg, c_op;

  always #5 clk = ~clk;

  blit_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .busy_o(busy), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_req && mem_we) begin
      mem[mem_addr[11:0]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end else if (mem_req) begin
      mem_rdata <= mem[mem_addr[11:0]];
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bmix(input int code, input logic [7:0] s, input logic [7:0] d);
    case (code)
      0: return 8'h00;       1: return s & d;
      2: return s & ~d;      3: return s;
      4: return ~s & d;      5: return d;
      6: return s ^ d;       7: return s | d;
      8: return ~s & ~d;     9: return s ^ ~d;
      10: return ~d;         11: return s | ~d;
      12: return ~s;         13: return ~s | d;
      14: return ~s | ~d;    default: return 8'hff;
    endcase
  endfunction

  task automatic init_mem(input int seed);
    for (int i = 0; i < 4096; i++)
      mem[i] = (i % 3 == 0) ? 8'h00 : 8'((i * 37 + seed * 11 + 5) & 255);
  endtask

  task automatic cfg(input logic [3:0] a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = 22'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic model;
    int ys, xs, sa, da, code;
    logic [7:0] s, sop;
    for (int i = 0; i < 4096; i++) expm[i] = mem[i];
    ys = (c_dir & 2) ? -1 : 1;
    xs = (c_dir & 1) ? -1 : 1;
    for (int r = 0; r <= c_h; r++)
      for (int c = 0; c <= c_w; c++) begin
        sa = (c_src + ys * r * (c_sp + 1) + xs * c) & 4095;
        da = (c_dst + ys * r * (c_dp + 1) + xs * c) & 4095;
        s = expm[sa];
        if (c_op[0]) s = ~s;
        if (c_op[5] || s != 0) begin sop = c_op[5] ? s : 8'(c_fg); code = c_mix & 15; end
        else begin sop = 8'(c_bg); code = (c_mix >> 4) & 15; end
        expm[da] = bmix(code, sop, expm[da]);
      end
  endtask

  task automatic program_regs;
    cfg(REG_SRC_START, c_src); cfg(REG_DST_START, c_dst);
    cfg(REG_SRC_PITCH, c_sp);  cfg(REG_DST_PITCH, c_dp);
    cfg(REG_WIDTH, c_w);       cfg(REG_HEIGHT, c_h);
    cfg(REG_DIR, c_dir);       cfg(REG_MIX, c_mix);
    cfg(REG_FG_COL, c_fg);     cfg(REG_BG_COL, c_bg);
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy && cyc < 50000) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic check_mem(input string req);
    int bad = 0, first = -1;
    for (int i = 0; i < 4096; i++)
      if (mem[i] !== expm[i]) begin bad++; if (first < 0) first = i; end
    if (first >= 0) check(req, int'(mem[first]), int'(expm[first]));
    else check(req, 0, 0);
  endtask

  // full blit: R2 busy rise, R5 write count, R12 busy length, memory image
  task automatic do_blit(input string req, input bit timing);
    int cyc, npix;
    npix = (c_w + 1) * (c_h + 1);
    program_regs();
    model();
    wr_cnt = 0;
    cfg(REG_OP, c_op);
    if (timing) check({"R2 busy after start ", req}, int'(busy), 1);
    wait_idle(cyc);
    if (timing) begin
      check({"R12 busy cycles ", req}, cyc, 3 * npix);
      check({"R5 write count ", req}, wr_cnt, npix);
    end
    check_mem(req);
  endtask

  task automatic t_reset;
    check("R1 busy after reset", int'(busy), 0);
    check("R1 no request after reset", int'(mem_req), 0);
  endtask

  task automatic t_plain_copy;
    init_mem(1);
    c_src = 16; c_dst = 1024; c_sp = 15; c_dp = 63; c_w = 3; c_h = 2;
    c_dir = 0; c_mix = 8'h03; c_fg = 0; c_bg = 0; c_op = 8'h28;
    do_blit("R6 R9 R13 copy", 1'b1);
  endtask

  task automatic t_all_mixes;
    for (int m = 0; m < 16; m++) begin
      init_mem(m + 2);
      c_src = 200; c_dst = 600; c_sp = 15; c_dp = 15; c_w = 1; c_h = 1;
      c_dir = 0; c_mix = m; c_fg = 0; c_bg = 0; c_op = 8'h28;
      do_blit($sformatf("R8 mix %0d", m), 1'b0);
    end
  endtask

  task automatic t_overlap_x;
    init_mem(20);
    c_src = 110; c_dst = 112; c_sp = 31; c_dp = 31; c_w = 5; c_h = 1;
    c_dir = 1; c_mix = 8'h03; c_fg = 0; c_bg = 0; c_op = 8'h28;
    do_blit("R6 R7 overlap right-to-left", 1'b1);
  endtask

  task automatic t_overlap_y;
    init_mem(21);
    c_src = 300 + 3 * 32; c_dst = 300 + 4 * 32; c_sp = 31; c_dp = 31; c_w = 4; c_h = 3;
    c_dir = 2; c_mix = 8'h03; c_fg = 0; c_bg = 0; c_op = 8'h28;
    do_blit("R6 R7 overlap bottom-up", 1'b1);
  endtask

  task automatic t_both_neg;
    init_mem(22);
    c_src = 2000; c_dst = 3000; c_sp = 20; c_dp = 47; c_w = 2; c_h = 2;
    c_dir = 3; c_mix = 8'h06; c_fg = 0; c_bg = 0; c_op = 8'h28;
    do_blit("R6 both negative", 1'b1);
  endtask

  task automatic t_fixed_colour;
    init_mem(23);
    c_src = 0; c_dst = 1500; c_sp = 15; c_dp = 15; c_w = 5; c_h = 2;
    c_dir = 0; c_mix = 8'h76; c_fg = 8'hA5; c_bg = 8'h3C; c_op = 8'h08;
    do_blit("R10 fixed colour mask", 1'b1);
  endtask

  task automatic t_inverted;
    init_mem(24);
    c_src = 48; c_dst = 1800; c_sp = 15; c_dp = 15; c_w = 3; c_h = 1;
    c_dir = 0; c_mix = 8'h03; c_fg = 0; c_bg = 0; c_op = 8'h29;
    do_blit("R11 inverted source", 1'b1);
    init_mem(25);
    c_mix = 8'hC3; c_fg = 8'h5A; c_bg = 8'h81; c_op = 8'h09;
    do_blit("R11 R10 inverted mask", 1'b0);
  endtask

  task automatic t_bad_opcode;
    bit moved = 0;
    init_mem(26);
    c_src = 16; c_dst = 900; c_sp = 15; c_dp = 15; c_w = 1; c_h = 1;
    c_dir = 0; c_mix = 8'h0F; c_fg = 0; c_bg = 0;
    program_regs();
    wr_cnt = 0;
    cfg(REG_OP, 8'h2A);
    for (int i = 0; i < 6; i++) begin
      if (busy) moved = 1;
      @(negedge clk);
    end
    check("R3 busy after bad opcode", int'(moved), 0);
    check("R3 writes after bad opcode", wr_cnt, 0);
  endtask

  task automatic t_write_while_busy;
    int cyc;
    init_mem(27);
    c_src = 64; c_dst = 2500; c_sp = 15; c_dp = 15; c_w = 3; c_h = 3;
    c_dir = 0; c_mix = 8'h07; c_fg = 0; c_bg = 0; c_op = 8'h28;
    program_regs();
    model();
    wr_cnt = 0;
    cfg(REG_OP, c_op);
    cfg(REG_DST_START, 3500);
    cfg(REG_MIX, 8'h00);
    cfg(REG_OP, 8'h28);
    wait_idle(cyc);
    check("R4 write count with ignored writes", wr_cnt, 16);
    check_mem("R4 result unaffected");
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    init_mem(0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain_copy();
    t_all_mixes();
    t_overlap_x();
    t_overlap_y();
    t_both_neg();
    t_fixed_colour();
    t_inverted();
    t_bad_opcode();
    t_write_while_busy();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule